// File: doc/BRIEF.md
# Line-locked horizontal blanking generator

This block produces the horizontal blanking gate that forces the RGB video outputs to their blanking level. It runs from a clock that is locked to the line. It watches the horizontal flyback pulse and predicts where the centre of the next flyback will fall. It measures the previous line's period (flyback rising edge to the next rising edge) and the previous pulse's width (rising edge to falling edge). From these it places the next centre at one period plus half a width after the last rising edge. The normal blank opens a programmable number of clocks before that predicted centre and closes when the flyback pulse falls.

A second, wide blank can be enabled. It is timed from the horizontal oscillator's reference pulse rather than from the flyback, so it still masks the picture edges when the scan amplitude is reduced. Its phase is programmable. Its length is the expected normal-blank length plus a fixed margin on each side, and the margin is chosen by the line-rate mode. The output is the registered OR of both gates. Until a full flyback measurement exists, the output is held active.

Top module: `hblank_gen`

## Requirements
- R1: From reset, `blank_o` is 1. It stays 1 until the first flyback falling edge that follows the second detected flyback rising edge.
- R2: The period P is the number of clock edges between two consecutive edges that detect flyback rising. The width W is the number of edges from a rising detection to the following falling detection. Both are re-measured on every line, and the most recent values drive the prediction.
- R3: Let R be the edge that first samples `flyback_i` high. When the output is not held by R1, the normal blank drives `blank_o` to 1 from edge R + P + floor(W/2) - L + 1 onwards, where L is the lead.
- R4: The lead is L = 40 + 2*c clocks, where c is the unsigned 4-bit value on `start_code_i` (0 to 15).
- R5: The normal blank ends at the edge F that first samples `flyback_i` low. `blank_o` returns to 0 after edge F + 1 unless the wide blank is active. A rise and a fall of the gate at the same edge resolve to the fall.
- R6: With `wide_en_i` = 1, let H be the edge that first samples `href_i` high. The wide blank drives `blank_o` to 1 from edge H + 2*p + 2, where p is the unsigned 4-bit value on `wide_phase_i`.
- R7: The wide blank lasts L + W - floor(W/2) + 2*X clocks. X is parameter `EXT_1FH` when `mode_2fh_i` = 0 and `EXT_2FH` when `mode_2fh_i` = 1 (both default to 7).
- R8: With `wide_en_i` = 0, the wide blank is cleared within one edge and has no effect on `blank_o`.
- R9: `blank_o` is a register holding the OR of the normal gate, the wide gate and the not-yet-measured condition, one clock after those gates change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked clock |
| rst | input | 1 | Synchronous active-high reset |
| flyback_i | input | 1 | Horizontal flyback pulse, active high |
| href_i | input | 1 | Horizontal oscillator reference pulse, active high |
| mode_2fh_i | input | 1 | 0: single line rate, 1: double line rate (selects wide margin) |
| start_code_i | input | 4 | Normal-blank lead code, 2 clocks per step |
| wide_en_i | input | 1 | Enables the wide blank |
| wide_phase_i | input | 4 | Wide-blank delay from the reference pulse, 2 clocks per step |
| blank_o | output | 1 | Registered horizontal blanking gate |

## Verification
The hardest state to reach from the ports is the steady case. There, the blank that opens late in one line is driven by the previous line's period and width, and it closes on the next line's flyback. A wide window started by a late reference pulse may also run across the line boundary. The stimulus holds each setting, whether random or directed, for four identical lines and compares every cycle of the last two against a window model. Directed cases cover an odd pulse width, the extreme lead and phase codes, both modes with different margins, and a reference pulse near the end of the line, so that the wrapped overlap is reached on purpose.

// File: rtl/hblank_pkg.sv
package hblank_pkg;

  // Rise/fall event pair from a single-bit input.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_FLY = 0;
  localparam int unsigned SRC_REF = 1;

endpackage

// File: rtl/hbl_edge_det.sv
module hbl_edge_det
  import hblank_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sig_i,
  output edge_t ev_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  always_comb begin
    ev_o.rise = sig_i & ~prev_q;
    ev_o.fall = ~sig_i & prev_q;
  end

endmodule

// File: rtl/hbl_line_meas.sv
module hbl_line_meas
  import hblank_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  edge_t            fly_ev_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] wid_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, per_q, wid_q, cnt_inc;
  logic             seen_q, valid_q;

  // Saturating count of edges since the last flyback rise.
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= CNT_MAX;
      per_q   <= '0;
      wid_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (fly_ev_i.rise) begin
        cnt_q  <= '0;
        seen_q <= 1'b1;
        if (seen_q) begin
          per_q   <= cnt_inc;   // R2: rise-to-rise period
          valid_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_inc;
      end
      if (fly_ev_i.fall && seen_q) wid_q <= cnt_inc;  // R2: pulse width
    end
  end

  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
  assign wid_o   = wid_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/hbl_normal_gate.sv
module hbl_normal_gate #(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned BASE_LEAD = 40,
  parameter int unsigned LEAD_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic [CNT_W-1:0]  wid_i,
  input  logic              valid_i,
  input  logic              fall_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ngate_o,
  output logic [CNT_W+1:0]  lead_o
);

  localparam int unsigned SUM_W = CNT_W + 2;

  logic [SUM_W-1:0] lead_w, centre_w, target_w;
  logic             hit;
  logic             ngate_q;

  // R4: lead grows by LEAD_STEP per code step.
  // R3: start count = period + half width - 1 - lead (clamped at 0).
  always_comb begin
    lead_w   = SUM_W'(BASE_LEAD) + SUM_W'(LEAD_STEP) * SUM_W'(code_i);
    centre_w = SUM_W'(per_i) + SUM_W'(wid_i >> 1);
    if (centre_w > lead_w) target_w = centre_w - lead_w - SUM_W'(1);
    else                   target_w = '0;
  end

  assign hit = valid_i && (SUM_W'(cnt_i) == target_w);

  // Held active from reset (R1); the trailing edge wins over a start (R5).
  always_ff @(posedge clk) begin
    if (rst)                   ngate_q <= 1'b1;
    else if (fall_i && valid_i) ngate_q <= 1'b0;
    else if (hit)               ngate_q <= 1'b1;
  end

  assign ngate_o = ngate_q;
  assign lead_o  = lead_w;

endmodule

// File: rtl/hbl_wide_gate.sv
module hbl_wide_gate #(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned WIDE_STEP = 2,
  parameter int unsigned EXT_1FH   = 7,
  parameter int unsigned EXT_2FH   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_rise_i,
  input  logic              wide_en_i,
  input  logic [CODE_W-1:0] phase_i,
  input  logic              mode_2fh_i,
  input  logic [CNT_W+1:0]  lead_i,
  input  logic [CNT_W-1:0]  wid_i,
  output logic              wgate_o
);

  localparam int unsigned      SUM_W   = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hcnt_q;
  logic [SUM_W-1:0] ext_w, ph_w, span_w, end_w;
  logic             wgate_q;

  // R7: margin per side chosen by line-rate mode; span covers the
  // expected normal blank plus both margins.
  always_comb begin
    ext_w  = mode_2fh_i ? SUM_W'(EXT_2FH) : SUM_W'(EXT_1FH);
    span_w = lead_i + SUM_W'(wid_i) - SUM_W'(wid_i >> 1) + (ext_w << 1);
    ph_w   = SUM_W'(WIDE_STEP) * SUM_W'(phase_i);   // R6
    end_w  = ph_w + span_w;
  end

  // Saturating count of edges since the oscillator reference rise.
  always_ff @(posedge clk) begin
    if (rst)                  hcnt_q <= CNT_MAX;
    else if (ref_rise_i)      hcnt_q <= '0;
    else if (hcnt_q != CNT_MAX) hcnt_q <= hcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                              wgate_q <= 1'b0;
    else if (!wide_en_i)                  wgate_q <= 1'b0;  // R8
    else if (SUM_W'(hcnt_q) == ph_w)      wgate_q <= 1'b1;
    else if (SUM_W'(hcnt_q) == end_w)     wgate_q <= 1'b0;
  end

  assign wgate_o = wgate_q;

endmodule

// File: rtl/hblank_gen.sv
module hblank_gen
  import hblank_pkg::*;
#(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned BASE_LEAD = 40,
  parameter int unsigned LEAD_STEP = 2,
  parameter int unsigned WIDE_STEP = 2,
  parameter int unsigned EXT_1FH   = 7,
  parameter int unsigned EXT_2FH   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flyback_i,
  input  logic              href_i,
  input  logic              mode_2fh_i,
  input  logic [CODE_W-1:0] start_code_i,
  input  logic              wide_en_i,
  input  logic [CODE_W-1:0] wide_phase_i,
  output logic              blank_o
);

  logic [NUM_SRC-1:0] raw;
  edge_t              ev [NUM_SRC];

  logic [CNT_W-1:0]   cnt, per, wid;
  logic [CNT_W+1:0]   lead;
  logic               meas_valid, ngate, wgate, blank_q;

  assign raw[SRC_FLY] = flyback_i;
  assign raw[SRC_REF] = href_i;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_edge
    hbl_edge_det u_edge (
      .clk   (clk),
      .rst   (rst),
      .sig_i (raw[gi]),
      .ev_o  (ev[gi])
    );
  end

  hbl_line_meas #(.CNT_W(CNT_W)) u_meas (
    .clk      (clk),
    .rst      (rst),
    .fly_ev_i (ev[SRC_FLY]),
    .cnt_o    (cnt),
    .per_o    (per),
    .wid_o    (wid),
    .valid_o  (meas_valid)
  );

  hbl_normal_gate #(
    .CNT_W(CNT_W), .CODE_W(CODE_W),
    .BASE_LEAD(BASE_LEAD), .LEAD_STEP(LEAD_STEP)
  ) u_norm (
    .clk     (clk),
    .rst     (rst),
    .cnt_i   (cnt),
    .per_i   (per),
    .wid_i   (wid),
    .valid_i (meas_valid),
    .fall_i  (ev[SRC_FLY].fall),
    .code_i  (start_code_i),
    .ngate_o (ngate),
    .lead_o  (lead)
  );

  hbl_wide_gate #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .WIDE_STEP(WIDE_STEP),
    .EXT_1FH(EXT_1FH), .EXT_2FH(EXT_2FH)
  ) u_wide (
    .clk        (clk),
    .rst        (rst),
    .ref_rise_i (ev[SRC_REF].rise),
    .wide_en_i  (wide_en_i),
    .phase_i    (wide_phase_i),
    .mode_2fh_i (mode_2fh_i),
    .lead_i     (lead),
    .wid_i      (wid),
    .wgate_o    (wgate)
  );

  // R9: registered merge of both gates and the unmeasured hold.
  always_ff @(posedge clk) begin
    if (rst) blank_q <= 1'b1;
    else     blank_q <= ~meas_valid | ngate | wgate;
  end

  assign blank_o = blank_q;

  // R1: no measurement yet -> output stays active.
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |=> blank_o);

  // R3: normal gate opening reaches the output one clock later.
  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ngate) |=> blank_o);

  // R5: trailing flyback edge with no wide blank releases the output.
  p_end_r5: assert property (@(posedge clk) disable iff (rst)
    (ev[SRC_FLY].fall && meas_valid && !wide_en_i) |=> ##1 !blank_o);

  // R8: wide disabled on two edges and normal gate closed -> output low.
  p_no_wide_r8: assert property (@(posedge clk) disable iff (rst)
    (!wide_en_i && $past(!wide_en_i) && !ngate && meas_valid) |=> !blank_o);

endmodule

// File: tb/hblank_gen_tb.sv
module hblank_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int EXT1       = 7;
  localparam int EXT2       = 5;
  localparam int NLINES     = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       flyback, href, mode_2fh, wide_en;
  logic [3:0] start_code, wide_phase;
  logic       blank;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hblank_gen #(.EXT_1FH(EXT1), .EXT_2FH(EXT2)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .flyback_i    (flyback),
    .href_i       (href),
    .mode_2fh_i   (mode_2fh),
    .start_code_i (start_code),
    .wide_en_i    (wide_en),
    .wide_phase_i (wide_phase),
    .blank_o      (blank)
  );

  // Normal window at line edge e (R3, R4, R5), steady lines of P clocks.
  function automatic bit exp_norm(int e, int p, int w, int ofs);
    int lead = 40 + 2 * ofs;
    return (e <= w) || (e >= p + w / 2 - lead + 1);
  endfunction

  // Wide window at line edge e (R6, R7), wraps modulo the line.
  function automatic bit exp_wide(int e, int p, int w, int ofs, bit wen,
                                  int ph, bit mode, int hoff);
    int lead = 40 + 2 * ofs;
    int wl   = lead + w - w / 2 + 2 * (mode ? EXT2 : EXT1);
    int d    = e - hoff - 2 * ph - 2;
    while (d < 0) d += p;
    return wen && (d < wl);
  endfunction

  task automatic check_bit(string tag, int seg, int line, int e,
                           logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s seg=%0d line=%0d edge=%0d actual=%0b expected=%0b",
               tag, seg, line, e, act, exp);
    end
  endtask

  // Drives NLINES identical lines; checks the last two every cycle.
  task automatic run_seg(int seg, int p, int w, int ofs, bit wen, int ph,
                         bit mode, int hoff, bit first);
    start_code = 4'(ofs);
    wide_en    = wen;
    wide_phase = 4'(ph);
    mode_2fh   = mode;
    for (int l = 0; l < NLINES; l++) begin
      for (int j = 0; j < p; j++) begin
        @(negedge clk);
        if (first && l == 0 && j > 0)
          check_bit("R1 hold", seg, l, j - 1, blank, 1'b1);
        if (l >= 2) begin
          int  e  = (j == 0) ? p - 1 : j - 1;
          bit  en = exp_norm(e, p, w, ofs);
          bit  ew = exp_wide(e, p, w, ofs, wen, ph, mode, hoff);
          string tag;
          if (en)       tag = "R3 R4 R9";
          else if (ew)  tag = "R6 R7 R9";
          else if (wen) tag = "R5 R7";
          else          tag = "R5 R8";
          check_bit(tag, seg, l, e, blank, en | ew);
        end
        flyback = (j < w);
        href    = (j == hoff);
      end
    end
  endtask

  task automatic run_all();
    int seg = 0;
    rst = 1'b1; flyback = 1'b0; href = 1'b0; mode_2fh = 1'b0;
    wide_en = 1'b0; start_code = '0; wide_phase = '0;
    repeat (4) @(negedge clk);
    check_bit("R1 reset", seg, 0, 0, blank, 1'b1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R1 idle", seg, 0, 0, blank, 1'b1);
    // R1, R3, R4 code 0, R8 wide off
    run_seg(seg++, 300, 40, 0, 1'b0, 0, 1'b0, 0, 1'b1);
    // R4 largest code with widest pulse
    run_seg(seg++, 300, 70, 15, 1'b0, 0, 1'b0, 0, 1'b0);
    // R2 odd width, R6 phase 0, R7 single-rate margin
    run_seg(seg++, 300, 41, 5, 1'b1, 0, 1'b0, 100, 1'b0);
    // R7 double-rate margin, R6 phase 15
    run_seg(seg++, 300, 41, 5, 1'b1, 15, 1'b1, 100, 1'b0);
    // R6 window wrapping across the line boundary, R9 merge
    run_seg(seg++, 260, 30, 3, 1'b1, 7, 1'b1, 250, 1'b0);
    // R2 period change to a short line
    run_seg(seg++, 210, 25, 9, 1'b1, 2, 1'b0, 30, 1'b0);
    for (int k = 0; k < 24; k++) begin
      int p    = $urandom_range(480, 200);
      int w    = $urandom_range(70, 20);
      int ofs  = $urandom_range(15, 0);
      bit wen  = 1'($urandom_range(1, 0));
      int ph   = $urandom_range(15, 0);
      bit mode = 1'($urandom_range(1, 0));
      int hoff = $urandom_range(p - 1, 0);
      run_seg(seg++, p, w, ofs, wen, ph, mode, hoff, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule